// File: doc/BRIEF.md
# Instruction Decoder with Immediate Prefix

This block decodes the fixed-width 32-bit instruction words of a small soft RISC core. It splits each word into destination and source register indices, says whether the word uses the register format or the immediate format, and produces the resolved 32-bit immediate operand that the execute stage consumes. It also flags logical-AND instructions for the ALU.

By default a 16-bit immediate is sign-extended. A dedicated prefix instruction breaks that rule. It does not write a register. Instead, a one-entry latch keeps its 16-bit field, and that field becomes the upper half of the immediate of the next valid instruction, with no sign extension. Decoding is purely combinational from the current word and the latch. The latch changes only on a clock edge when the issue strobe is high.

Top module: `instr_decoder`

## Requirements
- R1: Field positions in the word: opcode in bits 31..26, rd in bits 25..21, ra in bits 20..16, rb in bits 15..11, function field in bits 10..0, and the 16-bit immediate in bits 15..0.
- R2: `imm_fmt_o` equals opcode bit 3 (word bit 29): 1 selects the immediate format and 0 selects the register format.
- R3: For an immediate-format word with no prefix pending, `imm_o` is the sign extension of bits 15..0 (0xF000 gives 0xFFFFF000).
- R4: For an immediate-format word with a prefix pending, `imm_o` is {latched 16 bits, bits 15..0} with no sign extension. For example, prefix 0x5002 followed by 0xF000 gives 0x5002F000. This also holds when the current word is itself a prefix.
- R5: A valid prefix word arms the latch. The next valid word of any kind consumes it. Cycles with `valid_i` low leave the latch unchanged. A prefix that follows a prefix re-arms the latch with its own value.
- R6: The prefix opcode is 101100. For it, `is_prefix_o` is 1 and `rd_we_o` is 0. For every other valid word, `rd_we_o` is 1. When `valid_i` is 0, `rd_we_o` is 0.
- R7: For a register-format word, `imm_o` is 0. If a prefix is pending, the word still clears the latch, and the latched value never appears in a later immediate.
- R8: `op_and_o` is 1 for opcode 100001 with a zero function field, and for opcode 101001. Otherwise it is 0.
- R9: Reset (active low, asynchronous) clears the latch, so a pending prefix is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word is issued this cycle |
| instr_i | input | 32 | Instruction word |
| rd_o | output | 5 | Destination register index |
| ra_o | output | 5 | First source register index |
| rb_o | output | 5 | Second source register index |
| imm_fmt_o | output | 1 | 1 = immediate format, 0 = register format |
| imm_o | output | 32 | Resolved immediate operand |
| is_prefix_o | output | 1 | Word is the immediate prefix instruction |
| rd_we_o | output | 1 | Word writes its destination register |
| op_and_o | output | 1 | Word is a logical AND (either format) |

## Verification
The hardest state to reach from the ports is a prefix that stays pending across idle issue cycles, or that is dropped by reset while armed. The port value depends on an earlier instruction, not on the current one. The vector walk puts an un-issued word between a prefix and its consumer, and chains two prefixes back to back. Directed steps then arm the latch, show the joined immediate while issue is held low, and assert reset before the consumer arrives.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;
  localparam int OPC_W = 6;
  localparam int REG_W = 5;
  localparam int IMM_W = 16;

  localparam logic [OPC_W-1:0] OPC_PREFIX = 6'b101100;
  localparam logic [OPC_W-1:0] OPC_AND_R  = 6'b100001;
  localparam logic [OPC_W-1:0] OPC_AND_I  = 6'b101001;
  localparam int               FMT_BIT    = 3;  // opcode bit that selects the immediate format
endpackage

// File: rtl/instr_field_split.sv
module instr_field_split #(
  parameter int OPC_W = 6,
  parameter int REG_W = 5,
  parameter int IMM_W = 16,
  localparam int XLEN   = 2 * IMM_W,
  localparam int FUNC_W = XLEN - OPC_W - 3 * REG_W
) (
  input  logic [XLEN-1:0]   word_i,
  output logic [OPC_W-1:0]  opc_o,
  output logic [REG_W-1:0]  rd_o,
  output logic [REG_W-1:0]  ra_o,
  output logic [REG_W-1:0]  rb_o,
  output logic [FUNC_W-1:0] func_o,
  output logic [IMM_W-1:0]  lo_o
);
  localparam int OPC_LSB = XLEN - OPC_W;
  localparam int RD_LSB  = OPC_LSB - REG_W;
  localparam int RA_LSB  = RD_LSB - REG_W;
  localparam int RB_LSB  = RA_LSB - REG_W;

  assign opc_o  = word_i[OPC_LSB +: OPC_W];
  assign rd_o   = word_i[RD_LSB +: REG_W];
  assign ra_o   = word_i[RA_LSB +: REG_W];
  assign rb_o   = word_i[RB_LSB +: REG_W];
  assign func_o = word_i[FUNC_W-1:0];
  assign lo_o   = word_i[IMM_W-1:0];
endmodule

// File: rtl/prefix_latch.sv
module prefix_latch #(
  parameter int IMM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             is_prefix_i,
  input  logic [IMM_W-1:0] lo_i,
  output logic             pend_o,
  output logic [IMM_W-1:0] hi_o
);
  // every issued word consumes the entry; a prefix re-arms it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      hi_o   <= '0;
    end else if (valid_i) begin
      pend_o <= is_prefix_i;
      if (is_prefix_i) hi_o <= lo_i;
    end
  end
endmodule

// File: rtl/imm_resolve.sv
module imm_resolve #(
  parameter int IMM_W = 16,
  localparam int XLEN = 2 * IMM_W
) (
  input  logic             imm_fmt_i,
  input  logic             pend_i,
  input  logic [IMM_W-1:0] hi_i,
  input  logic [IMM_W-1:0] lo_i,
  output logic [XLEN-1:0]  imm_o
);
  always_comb begin
    if (!imm_fmt_i)  imm_o = '0;
    else if (pend_i) imm_o = {hi_i, lo_i};
    else             imm_o = {{IMM_W{lo_i[IMM_W-1]}}, lo_i};
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_dec_pkg::*;
#(
  parameter int DEC_OPC_W = OPC_W,
  parameter int DEC_REG_W = REG_W,
  parameter int DEC_IMM_W = IMM_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [2*DEC_IMM_W-1:0] instr_i,
  output logic [DEC_REG_W-1:0]   rd_o,
  output logic [DEC_REG_W-1:0]   ra_o,
  output logic [DEC_REG_W-1:0]   rb_o,
  output logic                   imm_fmt_o,
  output logic [2*DEC_IMM_W-1:0] imm_o,
  output logic                   is_prefix_o,
  output logic                   rd_we_o,
  output logic                   op_and_o
);
  localparam int XLEN   = 2 * DEC_IMM_W;
  localparam int FUNC_W = XLEN - DEC_OPC_W - 3 * DEC_REG_W;

  logic [DEC_OPC_W-1:0] opc;
  logic [FUNC_W-1:0]    func;
  logic [DEC_IMM_W-1:0] lo;
  logic                 pfx_pend;
  logic [DEC_IMM_W-1:0] pfx_hi;

  instr_field_split #(
    .OPC_W(DEC_OPC_W), .REG_W(DEC_REG_W), .IMM_W(DEC_IMM_W)
  ) u_split (
    .word_i(instr_i), .opc_o(opc), .rd_o(rd_o), .ra_o(ra_o),
    .rb_o(rb_o), .func_o(func), .lo_o(lo)
  );

  assign imm_fmt_o   = opc[FMT_BIT];
  assign is_prefix_o = (opc == OPC_PREFIX[DEC_OPC_W-1:0]);
  assign rd_we_o     = valid_i & ~is_prefix_o;
  assign op_and_o    = ((opc == OPC_AND_R[DEC_OPC_W-1:0]) && (func == '0)) ||
                       (opc == OPC_AND_I[DEC_OPC_W-1:0]);

  prefix_latch #(.IMM_W(DEC_IMM_W)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .is_prefix_i(is_prefix_o), .lo_i(lo), .pend_o(pfx_pend), .hi_o(pfx_hi)
  );

  imm_resolve #(.IMM_W(DEC_IMM_W)) u_imm (
    .imm_fmt_i(imm_fmt_o), .pend_i(pfx_pend), .hi_i(pfx_hi),
    .lo_i(lo), .imm_o(imm_o)
  );
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk #(
  parameter int IMM_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [IMM_W-1:0]   lo_i,
  input logic               imm_fmt_i,
  input logic [2*IMM_W-1:0] imm_i,
  input logic               is_prefix_i,
  input logic               rd_we_i,
  input logic               pend_i,
  input logic [IMM_W-1:0]   hi_i
);
  // R5
  pfx_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && is_prefix_i) |=> (pend_i && hi_i == $past(lo_i)));
  // R5
  pfx_consume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !is_prefix_i) |=> !pend_i);
  // R5
  pfx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(pend_i) && $stable(hi_i)));
  // R4
  imm_join_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imm_fmt_i && pend_i) |-> imm_i == {hi_i, lo_i});
  // R3
  imm_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imm_fmt_i && !pend_i) |-> imm_i == {{IMM_W{lo_i[IMM_W-1]}}, lo_i});
  // R7
  reg_imm_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !imm_fmt_i |-> imm_i == '0);
  // R6
  pfx_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_prefix_i |-> !rd_we_i);
  // R9
  always @(negedge clk_i)
    if (!rst_ni) rst_clear_chk: assert (!pend_i);
endmodule

bind instr_decoder instr_decoder_chk #(.IMM_W(DEC_IMM_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .lo_i(instr_i[DEC_IMM_W-1:0]), .imm_fmt_i(imm_fmt_o), .imm_i(imm_o),
  .is_prefix_i(is_prefix_o), .rd_we_i(rd_we_o), .pend_i(pfx_pend), .hi_i(pfx_hi)
);

// File: tb/instr_decoder_tb.sv
`timescale 1ns/1ps
module instr_decoder_tb;
  localparam logic [5:0] OP_PFX  = 6'b101100;
  localparam logic [5:0] OP_ANDR = 6'b100001;
  localparam logic [5:0] OP_ANDI = 6'b101001;
  localparam logic [5:0] OP_ADDI = 6'b001000;
  localparam logic [5:0] OP_ADD  = 6'b000000;

  function automatic logic [31:0] mk_b(logic [5:0] op, logic [4:0] d, logic [4:0] a, logic [15:0] k);
    return {op, d, a, k};
  endfunction
  function automatic logic [31:0] mk_a(logic [5:0] op, logic [4:0] d, logic [4:0] a, logic [4:0] b, logic [10:0] f);
    return {op, d, a, b, f};
  endfunction

  typedef struct packed {
    logic        v;
    logic [31:0] ins;
    logic [31:0] imm;
    logic        fmt;
    logic        pfx;
    logic        we;
    logic        andf;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{1'b1, mk_b(OP_ANDI, 5'd10, 5'd10, 16'hF000), 32'hFFFFF000, 1'b1, 1'b0, 1'b1, 1'b1}, // R3 R8
    '{1'b1, mk_b(OP_PFX,  5'd0,  5'd0,  16'h5002), 32'h00005002, 1'b1, 1'b1, 1'b0, 1'b0}, // R6
    '{1'b1, mk_b(OP_ANDI, 5'd10, 5'd10, 16'hF000), 32'h5002F000, 1'b1, 1'b0, 1'b1, 1'b1}, // R4
    '{1'b1, mk_b(OP_ANDI, 5'd7,  5'd2,  16'hF000), 32'hFFFFF000, 1'b1, 1'b0, 1'b1, 1'b1}, // R5 consumed
    '{1'b1, mk_b(OP_PFX,  5'd0,  5'd0,  16'h1234), 32'h00001234, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b0, mk_b(OP_ADDI, 5'd1,  5'd1,  16'h0001), 32'h12340001, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 idle keeps
    '{1'b1, mk_b(OP_ADDI, 5'd1,  5'd0,  16'h8001), 32'h12348001, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b1, mk_b(OP_PFX,  5'd0,  5'd0,  16'hABCD), 32'hFFFFABCD, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, mk_a(OP_ANDR, 5'd3,  5'd4,  5'd5, 11'h000), 32'h0, 1'b0, 1'b0, 1'b1, 1'b1},  // R7
    '{1'b1, mk_b(OP_ADDI, 5'd31, 5'd30, 16'h7FFF), 32'h00007FFF, 1'b1, 1'b0, 1'b1, 1'b0}, // R7
    '{1'b1, mk_b(OP_PFX,  5'd0,  5'd0,  16'h0001), 32'h00000001, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, mk_b(OP_PFX,  5'd0,  5'd0,  16'hFFFF), 32'h0001FFFF, 1'b1, 1'b1, 1'b0, 1'b0}, // R4 on prefix
    '{1'b1, mk_b(OP_ADDI, 5'd2,  5'd3,  16'h0000), 32'hFFFF0000, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 re-arm
    '{1'b1, mk_a(OP_ANDR, 5'd8,  5'd9,  5'd10, 11'h001), 32'h0, 1'b0, 1'b0, 1'b1, 1'b0}, // R8 func
    '{1'b1, mk_a(OP_ADD,  5'd0,  5'd31, 5'd1, 11'h000), 32'h0, 1'b0, 1'b0, 1'b1, 1'b0}   // R2
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic [4:0]  rd, ra, rb;
  logic        imm_fmt, is_pfx, rd_we, op_and;
  logic [31:0] imm;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  instr_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .rd_o(rd), .ra_o(ra), .rb_o(rb), .imm_fmt_o(imm_fmt), .imm_o(imm),
    .is_prefix_o(is_pfx), .rd_we_o(rd_we), .op_and_o(op_and)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    instr = mk_b(OP_ANDI, 5'd1, 5'd1, 16'hF000);
    repeat (3) @(negedge clk);
    chk("R9 reset imm", imm, 32'hFFFFF000);
    chk("R6 reset we", {31'b0, rd_we}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      valid = VT[i].v;
      instr = VT[i].ins;
      #2;
      chk("R1 rd", {27'b0, rd}, {27'b0, VT[i].ins[25:21]});
      chk("R1 ra", {27'b0, ra}, {27'b0, VT[i].ins[20:16]});
      chk("R1 rb", {27'b0, rb}, {27'b0, VT[i].ins[15:11]});
      chk("R2 fmt", {31'b0, imm_fmt}, {31'b0, VT[i].fmt});
      chk("R3/R4/R7 imm", imm, VT[i].imm);
      chk("R6 prefix", {31'b0, is_pfx}, {31'b0, VT[i].pfx});
      chk("R6 we", {31'b0, rd_we}, {31'b0, VT[i].we});
      chk("R8 and", {31'b0, op_and}, {31'b0, VT[i].andf});
    end

    // R9: drop an armed prefix by reset
    @(negedge clk);
    valid = 1'b1;
    instr = mk_b(OP_PFX, 5'd0, 5'd0, 16'h4444);
    @(negedge clk);
    valid = 1'b0;
    instr = mk_b(OP_ANDI, 5'd1, 5'd1, 16'hF000);
    #2;
    chk("R5 armed idle", imm, 32'h4444F000);
    rst_n = 1'b0;
    #2;
    chk("R9 async clear", imm, 32'hFFFFF000);
    @(negedge clk);
    rst_n = 1'b1;
    valid = 1'b1;
    #2;
    chk("R9 after release", imm, 32'hFFFFF000);
    @(negedge clk);
    valid = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
      $finish;
    end
  end
endmodule